// File: doc/BRIEF.md
# Amplifier Output-Stage Protection and Enable Controller

This block decides, once per reference clock, whether the power output stage of a digital audio amplifier may switch. It merges a power-down request, a mute request and a set of fault indications into one registered enable. It also drives an open-drain warning pin that is either pulled low or left floating. Each fault class has its own rules. An over-current event stays latched. A thermal fault follows its flag. An undervoltage fault releases only above a higher startup threshold. A slow or stopped bit clock silences the stage without raising the warning. A DC-input fault from a separate detector blocks the stage for as long as it is present.

All analog comparators are modelled as digital flags. Every input passes a two-flop synchronizer into the reference clock domain. The bit-clock monitor counts rising bit-clock edges over a fixed window of reference cycles. When the warning pin is wired back to the power-down input, a latched over-current clears itself. The warning pulls power-down active, and power-down clears the latch, which releases the warning again.

Top module: `amp_prot_ctrl`

## Requirements
- R1: After synchronous reset, `stage_en`, `warn_pull` and `line_run` are 0, and the bit clock is treated as stopped until one full window has counted enough edges.
- R2: While `sleep_n` is 0, `stage_en` and `line_run` are 0, `warn_pull` is 0 (high-impedance), and the over-current, thermal and undervoltage states are cleared.
- R3: While `mute_n` is 0 and `sleep_n` is 1, `stage_en` is 0, `line_run` stays 1 and `warn_pull` is unaffected.
- R4: A high `ocp_det` latches an over-current fault that forces `stage_en` to 0 and `warn_pull` to 1. The fault persists after `ocp_det` falls and clears only on reset or while `sleep_n` is 0.
- R5: While `hot_det` is 1, `stage_en` is 0 and `warn_pull` is 1. Both recover by themselves once `hot_det` returns to 0.
- R6: `uv12_low` or `uv5_low` at 1 sets an undervoltage fault with `stage_en` at 0 and `warn_pull` at 0. A low flag falling alone does not release it; release needs `uv12_ok` and `uv5_ok` both at 1, or `sleep_n` at 0.
- R7: While the undervoltage fault is set, `warn_pull` is 0 even if an over-current or thermal fault is also present.
- R8: If fewer than `MIN_EDGES` rising `bclk` edges arrive in a window of `WINDOW` reference cycles, `stage_en` goes to 0 with `warn_pull` at 0. It returns to 1 after a window that counts enough edges.
- R9: While `dc_fault` is 1, `stage_en` is 0 and `warn_pull` is 0. Nothing is latched.
- R10: With `sleep_n` driven by the released-high warning pin, an over-current event ends with `stage_en` back at 1 without outside action.
- R11: `stage_en` is 1 only when awake, unmuted and free of every fault. With `bclk` running, it follows a change of a non-latching input within 6 reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset (power loss) |
| sleep_n | input | 1 | Power-down request, active low |
| mute_n | input | 1 | Output-stage mute, active low |
| ocp_det | input | 1 | Over-current comparator flag |
| hot_det | input | 1 | Over-temperature flag |
| uv12_low | input | 1 | High supply below shutdown threshold |
| uv12_ok | input | 1 | High supply above startup threshold |
| uv5_low | input | 1 | Logic supply below shutdown threshold |
| uv5_ok | input | 1 | Logic supply above startup threshold |
| dc_fault | input | 1 | Fault flag from the DC-input detector |
| bclk | input | 1 | Serial audio bit clock, asynchronous |
| stage_en | output | 1 | Registered output-stage enable |
| warn_pull | output | 1 | 1 pulls the open-drain warning low, 0 releases it |
| line_run | output | 1 | Line-level path active (awake) |

## Verification
On every cycle, the in-RTL assertions check several properties. A latched over-current survives while awake. Power-down clears all fault states and silences both outputs. Undervoltage forces the warning released. A pulled warning never coincides with an enabled stage. The edge counter never passes its limit. Only the bench scenarios can show the sequences: hysteresis release of undervoltage, recovery of the clock-stop detector after a good window, thermal self-recovery, and the warning-to-sleep loop that clears an over-current.

// File: rtl/amp_prot_pkg.sv
package amp_prot_pkg;

    typedef struct packed {
        logic sleep_n;
        logic mute_n;
        logic ocp;
        logic hot;
        logic uv12_low;
        logic uv12_ok;
        logic uv5_low;
        logic uv5_ok;
        logic dc;
        logic bclk;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);

    typedef struct packed {
        logic ocp;
        logic therm;
        logic uv;
        logic clk_stop;
        logic dc;
    } fault_t;

    function automatic logic any_fault(input fault_t f);
        return f.ocp | f.therm | f.uv | f.clk_stop | f.dc;
    endfunction

    // warning is pulled only by the two classes that report, and never under undervoltage
    function automatic logic warn_req(input fault_t f);
        return (f.ocp | f.therm) & ~f.uv;
    endfunction

endpackage

// File: rtl/aps_sync.sv
module aps_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/aps_clk_mon.sv
module aps_clk_mon #(
    parameter int WINDOW    = 64,
    parameter int MIN_EDGES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_s,
    output logic clk_stop
);
    localparam int WIN_W = $clog2(WINDOW);
    localparam int EC_W  = $clog2(MIN_EDGES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [EC_W-1:0]  EC_CAP   = EC_W'(MIN_EDGES);

    logic             bclk_d;
    logic [WIN_W-1:0] win_cnt;
    logic [EC_W-1:0]  edge_cnt;
    logic [EC_W-1:0]  edge_nxt;
    logic             rise;

    assign rise = bclk_s & ~bclk_d;

    always_comb begin
        if (rise && edge_cnt != EC_CAP) edge_nxt = edge_cnt + EC_W'(1);
        else                            edge_nxt = edge_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d   <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
            clk_stop <= 1'b1;
        end else begin
            bclk_d <= bclk_s;
            if (win_cnt == WIN_LAST) begin
                win_cnt  <= '0;
                edge_cnt <= '0;
                clk_stop <= (edge_nxt < EC_CAP);
            end else begin
                win_cnt  <= win_cnt + WIN_W'(1);
                edge_cnt <= edge_nxt;
            end
        end
    end

    p_edge_sat_r8: assert property (@(posedge clk) disable iff (rst)
        edge_cnt <= EC_CAP);

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (win_cnt != WIN_LAST) |=> $stable(clk_stop));
endmodule

// File: rtl/aps_fault_latch.sv
module aps_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic awake,
    input  logic ocp_s,
    input  logic hot_s,
    input  logic uv12_low_s,
    input  logic uv12_ok_s,
    input  logic uv5_low_s,
    input  logic uv5_ok_s,
    output logic ocp_q,
    output logic therm_q,
    output logic uv_q
);
    always_ff @(posedge clk) begin
        if (rst || !awake) begin
            ocp_q   <= 1'b0;
            therm_q <= 1'b0;
            uv_q    <= 1'b0;
        end else begin
            if (ocp_s) ocp_q <= 1'b1;
            therm_q <= hot_s;
            if (uv12_low_s || uv5_low_s)     uv_q <= 1'b1;
            else if (uv12_ok_s && uv5_ok_s)  uv_q <= 1'b0;
        end
    end

    p_ocp_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ocp_q && awake) |=> ocp_q);

    p_sleep_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !awake |=> (!ocp_q && !therm_q && !uv_q));

    p_uv_hyst_r6: assert property (@(posedge clk) disable iff (rst)
        (uv_q && awake && !(uv12_ok_s && uv5_ok_s)) |=> uv_q);
endmodule

// File: rtl/amp_prot_ctrl.sv
module amp_prot_ctrl
    import amp_prot_pkg::*;
#(
    parameter int WINDOW    = 64,
    parameter int MIN_EDGES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_n,
    input  logic mute_n,
    input  logic ocp_det,
    input  logic hot_det,
    input  logic uv12_low,
    input  logic uv12_ok,
    input  logic uv5_low,
    input  logic uv5_ok,
    input  logic dc_fault,
    input  logic bclk,
    output logic stage_en,
    output logic warn_pull,
    output logic line_run
);
    ctl_in_t raw_in;
    ctl_in_t syn_in;
    fault_t  flt;
    logic    ocp_q, therm_q, uv_q, clk_stop;

    assign raw_in = '{sleep_n: sleep_n, mute_n: mute_n, ocp: ocp_det, hot: hot_det,
                      uv12_low: uv12_low, uv12_ok: uv12_ok, uv5_low: uv5_low,
                      uv5_ok: uv5_ok, dc: dc_fault, bclk: bclk};

    aps_sync #(.W(CTL_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_in)
    );

    aps_fault_latch u_latch (
        .clk        (clk),
        .rst        (rst),
        .awake      (syn_in.sleep_n),
        .ocp_s      (syn_in.ocp),
        .hot_s      (syn_in.hot),
        .uv12_low_s (syn_in.uv12_low),
        .uv12_ok_s  (syn_in.uv12_ok),
        .uv5_low_s  (syn_in.uv5_low),
        .uv5_ok_s   (syn_in.uv5_ok),
        .ocp_q      (ocp_q),
        .therm_q    (therm_q),
        .uv_q       (uv_q)
    );

    aps_clk_mon #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) u_clkmon (
        .clk      (clk),
        .rst      (rst),
        .bclk_s   (syn_in.bclk),
        .clk_stop (clk_stop)
    );

    assign flt = '{ocp: ocp_q, therm: therm_q, uv: uv_q, clk_stop: clk_stop, dc: syn_in.dc};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_en  <= 1'b0;
            warn_pull <= 1'b0;
            line_run  <= 1'b0;
        end else begin
            stage_en  <= syn_in.sleep_n & syn_in.mute_n & ~any_fault(flt);
            warn_pull <= syn_in.sleep_n & warn_req(flt);
            line_run  <= syn_in.sleep_n;
        end
    end

    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !syn_in.sleep_n |=> (!warn_pull && !stage_en && !line_run));

    p_uv_release_r7: assert property (@(posedge clk) disable iff (rst)
        uv_q |=> !warn_pull);

    p_warn_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        warn_pull |-> !stage_en);

    p_stop_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        clk_stop |=> !stage_en);
endmodule

// File: tb/tb_amp_prot_ctrl.sv
module tb_amp_prot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;
    localparam int WIN_WAIT   = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_drv = 1'b0, loop_en = 1'b0;
    logic sleep_n, mute_n = 1'b1, ocp_det = 1'b0, hot_det = 1'b0;
    logic uv12_low = 1'b0, uv12_ok = 1'b1, uv5_low = 1'b0, uv5_ok = 1'b1;
    logic dc_fault = 1'b0, bclk = 1'b0;
    logic stage_en, warn_pull, line_run;
    int   bclk_half = 2;
    int   n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic saw_warn = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // open-drain warning pulled up, optionally looped back into power-down
    assign sleep_n = loop_en ? ~warn_pull : sleep_drv;

    amp_prot_ctrl dut (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .mute_n(mute_n),
        .ocp_det(ocp_det), .hot_det(hot_det), .uv12_low(uv12_low),
        .uv12_ok(uv12_ok), .uv5_low(uv5_low), .uv5_ok(uv5_ok),
        .dc_fault(dc_fault), .bclk(bclk), .stage_en(stage_en),
        .warn_pull(warn_pull), .line_run(line_run)
    );

    // bit clock generator, half period in reference cycles, 0 stops it
    initial begin
        forever begin
            @(negedge clk);
            if (bclk_half > 0) begin
                repeat (bclk_half - 1) @(negedge clk);
                bclk = ~bclk;
            end
        end
    end

    always @(negedge clk) if (warn_pull) saw_warn <= 1'b1;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_en(input logic slp, input logic mu, input logic dc,
                                    input logic hot, input logic ocp, input logic uv,
                                    input logic stop);
        return slp & mu & ~dc & ~hot & ~ocp & ~uv & ~stop;
    endfunction

    function automatic logic exp_warn(input logic slp, input logic hot,
                                      input logic ocp, input logic uv);
        return slp & ~uv & (hot | ocp);
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0a11);
        wait_cyc(4);
        // R1 reset state
        chk("R1 stage_en", stage_en, 1'b0);
        chk("R1 warn_pull", warn_pull, 1'b0);
        chk("R1 line_run", line_run, 1'b0);
        rst = 1'b0;
        sleep_drv = 1'b1;
        wait_cyc(10);
        // R1 clock treated as stopped before first full window
        chk("R1 startup gate", stage_en, 1'b0);
        wait_cyc(WIN_WAIT);
        chk("R11 all ok", stage_en, 1'b1);
        chk("R3 line_run awake", line_run, 1'b1);

        // R3 mute
        mute_n = 1'b0; wait_cyc(SETTLE);
        chk("R3 mute en", stage_en, 1'b0);
        chk("R3 mute line", line_run, 1'b1);
        chk("R3 mute warn", warn_pull, 1'b0);
        mute_n = 1'b1; wait_cyc(SETTLE);
        chk("R3 unmute", stage_en, 1'b1);

        // R4 over-current latch
        ocp_det = 1'b1; wait_cyc(3); ocp_det = 1'b0; wait_cyc(SETTLE);
        chk("R4 ocp en", stage_en, 1'b0);
        chk("R4 ocp warn", warn_pull, 1'b1);
        wait_cyc(50);
        chk("R4 ocp held", stage_en, 1'b0);

        // R7 undervoltage hides the warning while ocp is latched
        uv5_low = 1'b1; uv5_ok = 1'b0; wait_cyc(SETTLE);
        chk("R7 uv warn", warn_pull, 1'b0);
        chk("R6 uv en", stage_en, 1'b0);
        uv5_low = 1'b0; uv5_ok = 1'b1; wait_cyc(SETTLE);
        chk("R7 ocp warn back", warn_pull, 1'b1);

        // R2 sleep clears latch
        sleep_drv = 1'b0; wait_cyc(SETTLE);
        chk("R2 sleep en", stage_en, 1'b0);
        chk("R2 sleep warn", warn_pull, 1'b0);
        chk("R2 sleep line", line_run, 1'b0);
        sleep_drv = 1'b1; wait_cyc(SETTLE);
        chk("R2 ocp cleared", stage_en, 1'b1);
        chk("R2 warn cleared", warn_pull, 1'b0);

        // R5 thermal self recovery
        hot_det = 1'b1; wait_cyc(SETTLE);
        chk("R5 hot en", stage_en, 1'b0);
        chk("R5 hot warn", warn_pull, 1'b1);
        hot_det = 1'b0; wait_cyc(SETTLE);
        chk("R5 cool en", stage_en, 1'b1);
        chk("R5 cool warn", warn_pull, 1'b0);

        // R6 undervoltage hysteresis
        uv12_low = 1'b1; uv12_ok = 1'b0; wait_cyc(SETTLE);
        chk("R6 uv12 en", stage_en, 1'b0);
        chk("R6 uv12 warn", warn_pull, 1'b0);
        uv12_low = 1'b0; wait_cyc(SETTLE);
        chk("R6 between thresholds", stage_en, 1'b0);
        uv12_ok = 1'b1; wait_cyc(SETTLE);
        chk("R6 released", stage_en, 1'b1);
        uv12_low = 1'b1; uv12_ok = 1'b0; wait_cyc(SETTLE);
        uv12_low = 1'b0; sleep_drv = 1'b0; wait_cyc(SETTLE);
        sleep_drv = 1'b1; wait_cyc(SETTLE);
        chk("R6 sleep clears uv", stage_en, 1'b1);
        uv12_ok = 1'b1; wait_cyc(SETTLE);

        // R9 DC fault follows flag
        dc_fault = 1'b1; wait_cyc(SETTLE);
        chk("R9 dc en", stage_en, 1'b0);
        chk("R9 dc warn", warn_pull, 1'b0);
        dc_fault = 1'b0; wait_cyc(SETTLE);
        chk("R9 dc gone", stage_en, 1'b1);

        // R8 clock stop and slow clock
        bclk_half = 0; wait_cyc(WIN_WAIT);
        chk("R8 stopped en", stage_en, 1'b0);
        chk("R8 stopped warn", warn_pull, 1'b0);
        bclk_half = 2; wait_cyc(WIN_WAIT);
        chk("R8 recovered", stage_en, 1'b1);
        bclk_half = 16; wait_cyc(WIN_WAIT);
        chk("R8 slow en", stage_en, 1'b0);
        bclk_half = 2; wait_cyc(WIN_WAIT);
        chk("R8 fast again", stage_en, 1'b1);

        // R10 warning looped to power-down
        loop_en = 1'b1; saw_warn = 1'b0;
        ocp_det = 1'b1; wait_cyc(3); ocp_det = 1'b0;
        wait_cyc(40);
        chk("R10 warn pulsed", saw_warn, 1'b1);
        chk("R10 self cleared", stage_en, 1'b1);
        chk("R10 warn released", warn_pull, 1'b0);
        loop_en = 1'b0;
        wait_cyc(SETTLE);

        // R11 random non-latching combinations
        for (int i = 0; i < 40; i++) begin
            logic m, d, h;
            m = 1'($urandom_range(0, 3) != 0);
            d = 1'($urandom_range(0, 3) == 0);
            h = 1'($urandom_range(0, 3) == 0);
            mute_n = m; dc_fault = d; hot_det = h;
            wait_cyc(6);
            chk("R11 rand en", stage_en, exp_en(1'b1, m, d, h, 1'b0, 1'b0, 1'b0));
            chk("R5 rand warn", warn_pull, exp_warn(1'b1, h, 1'b0, 1'b0));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule